// File: doc/BRIEF.md
# Auxiliary Channel Transaction Sequencer

This block runs a single request on a display auxiliary channel for a host. The host presents a command nibble, a 20-bit target address, a byte count from 1 to 16 and up to sixteen write bytes packed into four 32-bit words, then pulses `start`. The sequencer waits for the channel to fall quiet, claims it through a request/grant handshake and confirms that a sink is attached. It then runs one or more attempts. Each attempt pulses a channel reset, waits out a back-off delay if it is a retry, and raises go until the channel reports completion. The block finishes with a one-cycle `done` that carries a 3-bit result code and, for reads, the reply words.

All waits are counted in microseconds derived from a clock-cycles-per-microsecond prescaler, so the same logic serves the real millisecond windows and the short windows used in a bench. The channel itself is abstract: one level input for activity, one grant, a sink-present flag, a completion pulse with an error byte, and reply words.

Top module: `aux_xact_seq`

## Requirements
- R1: Out of reset, `busy`, `done`, `ch_req`, `ch_reset`, `ch_go` and `ch_load` are all low.
- R2: After `start`, while `ch_active` stays high the sequencer waits at most IDLE_US microseconds, then ends with status BUSY (code 1) without raising `ch_req` or `ch_go`.
- R3: Once idle, `ch_req` rises; if `ch_grant` does not follow within GRANT_US microseconds the result is BUSY (code 1), and `ch_req` is low in the `done` cycle.
- R4: With the grant held but `ch_sink` low, the result is NODEV (code 2) and no `ch_load`, `ch_reset` or `ch_go` pulse occurs.
- R5: A command with bit 0 clear (write) produces exactly one single-cycle `ch_load` with `ch_wdata` equal to the host words, before the first reset pulse; a command with bit 0 set produces none.
- R6: While go is high, `ch_ctrl[15:12]` holds the command, `ch_ctrl[7:0]` holds the byte count minus one, the remaining bits are zero, and `ch_addr` holds the host address.
- R7: Every attempt starts with a one-cycle `ch_reset` pulse; on the first attempt go rises one cycle after reset falls, on later attempts BACKOFF_US microseconds plus two cycles after it.
- R8: `ch_go` stays high until `ch_done`; if no completion arrives within GO_US microseconds (go high for GO_US*CYC_PER_US+1 cycles) the transaction ends with TIMEOUT (code 3) and no further attempt is made.
- R9: An attempt succeeds when `ch_err` (two 4-bit error fields in [7:4] and [3:0]) is all zero at `ch_done`; failed attempts are retried up to MAX_TRIES attempts in all, after which the result is REMOTE_IO (code 4).
- R10: On success of a read command, `rdata` takes the value `ch_rdata` had at `ch_done`; after a write or a failure, `rdata` keeps its previous value.
- R11: `done` is high for exactly one cycle with `status` valid (OK is code 0), and `ch_req` is low in that cycle on every exit path.
- R12: When `ch_done` arrives in the very cycle the go window expires, the completion wins and the attempt is judged on its error byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transaction (taken only when not busy) |
| cmd | input | 4 | Command type; bit 0 set means read |
| addr | input | 20 | Target address |
| nbytes | input | 5 | Byte count, 1 to 16 |
| wdata | input | 128 | Write words, word 0 in bits 31:0 |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction strobe |
| status | output | 3 | Result code, valid with done |
| rdata | output | 128 | Reply words from the last successful read |
| ch_active | input | 1 | Channel busy or a previous request pending |
| ch_req | output | 1 | Ownership request |
| ch_grant | input | 1 | Ownership granted |
| ch_sink | input | 1 | Sink attached |
| ch_load | output | 1 | One-cycle strobe loading ch_wdata into the channel |
| ch_wdata | output | 128 | Write words towards the channel |
| ch_ctrl | output | 16 | Control word: command in 15:12, count minus one in 7:0 |
| ch_addr | output | 20 | Address towards the channel |
| ch_reset | output | 1 | Per-attempt channel reset pulse |
| ch_go | output | 1 | Attempt in flight, held until completion |
| ch_done | input | 1 | Attempt completion pulse |
| ch_err | input | 8 | Error fields sampled with ch_done |
| ch_rdata | input | 128 | Reply words sampled with ch_done |

## Verification
The go window and the completion pulse are the two functions that can land on one clock edge: the timer expiry and `ch_done` are both looked at in the waiting state. The bench's channel model counts the cycles go has been high and delivers `ch_done` exactly on the last cycle of the window, expecting OK, then one cycle later, expecting TIMEOUT with go having been high for GO_US*CYC_PER_US+1 cycles. Random transactions around these edges vary grant latency, completion latency and the number of failing attempts, and each result is compared with values the bench derives from the requirements.

// File: rtl/aux_xact_pkg.sv
package aux_xact_pkg;

   typedef enum logic [2:0] {
      RES_OK        = 3'd0,
      RES_BUSY      = 3'd1,
      RES_NODEV     = 3'd2,
      RES_TIMEOUT   = 3'd3,
      RES_REMOTE_IO = 3'd4
   } xact_res_e;

   typedef enum logic [3:0] {
      PH_IDLE,
      PH_WAIT_QUIET,
      PH_WAIT_GRANT,
      PH_CHECK_SINK,
      PH_LOAD,
      PH_RST_HI,
      PH_RST_LO,
      PH_BACKOFF,
      PH_IN_FLIGHT,
      PH_JUDGE,
      PH_FINISH
   } xact_phase_e;

endpackage

// File: rtl/aux_us_tick.sv
module aux_us_tick #(
   parameter int CYC_PER_US = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);
   localparam int PW = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;

   logic [PW-1:0] pre_q;

   if (CYC_PER_US < 1) begin : g_bad_cyc
      $error("aux_us_tick: CYC_PER_US must be at least 1");
   end

   assign tick = (pre_q == PW'(CYC_PER_US - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pre_q <= '0;
      else if (clr)   pre_q <= '0;
      else if (tick)  pre_q <= '0;
      else            pre_q <= pre_q + PW'(1);
   end

   // R8
   pre_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pre_q <= PW'(CYC_PER_US - 1));
endmodule

// File: rtl/aux_us_timer.sv
module aux_us_timer #(
   parameter int CNT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick,
   input  logic [CNT_W-1:0] limit,
   output logic             expired
);
   logic [CNT_W-1:0] cnt_q;

   if (CNT_W < 2) begin : g_bad_w
      $error("aux_us_timer: CNT_W must be at least 2");
   end

   assign expired = (cnt_q >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt_q <= '0;
      else if (clr)                cnt_q <= '0;
      else if (tick && !expired)   cnt_q <= cnt_q + CNT_W'(1);
   end

   // R8
   timer_saturates_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && expired) |=> (cnt_q == $past(cnt_q)) || (limit != $past(limit)));
endmodule

// File: rtl/aux_xact_fsm.sv
module aux_xact_fsm
   import aux_xact_pkg::*;
#(
   parameter int MAX_TRIES  = 32,
   parameter int TMR_W      = 11,
   parameter int IDLE_US    = 1000,
   parameter int GRANT_US   = 1000,
   parameter int GO_US      = 1000,
   parameter int BACKOFF_US = 400
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             is_read,
   input  logic             ch_active,
   input  logic             ch_grant,
   input  logic             ch_sink,
   input  logic             ch_done,
   input  logic             err_any,
   input  logic             tmr_exp,
   output logic             tmr_clr,
   output logic [TMR_W-1:0] tmr_limit,
   output logic             accept,
   output logic             sample_resp,
   output logic             commit_rd,
   output logic             busy,
   output logic             done,
   output logic [2:0]       status,
   output logic             ch_req,
   output logic             ch_load,
   output logic             ch_reset,
   output logic             ch_go
);
   localparam int TRY_W = $clog2(MAX_TRIES);

   xact_phase_e state_q, state_d;
   xact_res_e   res_q, res_d;
   logic [TRY_W-1:0] tries_q, tries_d;

   if (MAX_TRIES < 2) begin : g_bad_tries
      $error("aux_xact_fsm: MAX_TRIES must be at least 2");
   end

   always_comb begin
      state_d = state_q;
      res_d   = res_q;
      tries_d = tries_q;
      case (state_q)
         PH_IDLE: begin
            if (start) begin
               state_d = PH_WAIT_QUIET;
               tries_d = '0;
            end
         end
         PH_WAIT_QUIET: begin
            if (!ch_active) state_d = PH_WAIT_GRANT;
            else if (tmr_exp) begin
               state_d = PH_FINISH;
               res_d   = RES_BUSY;
            end
         end
         PH_WAIT_GRANT: begin
            if (ch_grant) state_d = PH_CHECK_SINK;
            else if (tmr_exp) begin
               state_d = PH_FINISH;
               res_d   = RES_BUSY;
            end
         end
         PH_CHECK_SINK: begin
            if (!ch_sink) begin
               state_d = PH_FINISH;
               res_d   = RES_NODEV;
            end else if (is_read) state_d = PH_RST_HI;
            else                  state_d = PH_LOAD;
         end
         PH_LOAD:  state_d = PH_RST_HI;
         PH_RST_HI: state_d = PH_RST_LO;
         PH_RST_LO: state_d = (tries_q == '0) ? PH_IN_FLIGHT : PH_BACKOFF;
         PH_BACKOFF: begin
            if (tmr_exp) state_d = PH_IN_FLIGHT;
         end
         PH_IN_FLIGHT: begin
            if (ch_done) state_d = PH_JUDGE;
            else if (tmr_exp) begin
               state_d = PH_FINISH;
               res_d   = RES_TIMEOUT;
            end
         end
         PH_JUDGE: begin
            if (!err_any) begin
               state_d = PH_FINISH;
               res_d   = RES_OK;
            end else if (tries_q == TRY_W'(MAX_TRIES - 1)) begin
               state_d = PH_FINISH;
               res_d   = RES_REMOTE_IO;
            end else begin
               state_d = PH_RST_HI;
               tries_d = tries_q + TRY_W'(1);
            end
         end
         PH_FINISH: state_d = PH_IDLE;
         default:   state_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PH_IDLE;
         res_q   <= RES_OK;
         tries_q <= '0;
      end else begin
         state_q <= state_d;
         res_q   <= res_d;
         tries_q <= tries_d;
      end
   end

   always_comb begin
      case (state_q)
         PH_WAIT_QUIET: tmr_limit = TMR_W'(IDLE_US);
         PH_WAIT_GRANT: tmr_limit = TMR_W'(GRANT_US);
         PH_BACKOFF:    tmr_limit = TMR_W'(BACKOFF_US);
         PH_IN_FLIGHT:  tmr_limit = TMR_W'(GO_US);
         default:       tmr_limit = '0;
      endcase
   end

   assign tmr_clr     = (state_d != state_q);
   assign accept      = (state_q == PH_IDLE) && start;
   assign sample_resp = (state_q == PH_IN_FLIGHT) && ch_done;
   assign commit_rd   = (state_q == PH_JUDGE) && !err_any && is_read;
   assign busy        = (state_q != PH_IDLE);
   assign done        = (state_q == PH_FINISH);
   assign status      = res_q;
   assign ch_req      = (state_q != PH_IDLE) && (state_q != PH_WAIT_QUIET)
                        && (state_q != PH_FINISH);
   assign ch_load     = (state_q == PH_LOAD);
   assign ch_reset    = (state_q == PH_RST_HI);
   assign ch_go       = (state_q == PH_IN_FLIGHT);

   // R4
   nodev_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PH_CHECK_SINK && !ch_sink) |=> (done && status == RES_NODEV));
   // R5
   load_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_load |-> !is_read);
   // R7
   go_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ch_go) |-> ($past(state_q) == PH_RST_LO || $past(state_q) == PH_BACKOFF));
   // R7
   retry_backs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ch_go) && tries_q != '0) |-> $past(state_q) == PH_BACKOFF);
   // R9
   tries_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tries_q <= TRY_W'(MAX_TRIES - 1));
   // R11
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R12
   done_beats_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PH_IN_FLIGHT && ch_done && tmr_exp) |=> state_q == PH_JUDGE);
endmodule

// File: rtl/aux_xact_seq.sv
module aux_xact_seq
   import aux_xact_pkg::*;
#(
   parameter int CYC_PER_US = 100,
   parameter int IDLE_US    = 1000,
   parameter int GRANT_US   = 1000,
   parameter int GO_US      = 1000,
   parameter int BACKOFF_US = 400,
   parameter int MAX_TRIES  = 32,
   parameter int ADDR_W     = 20,
   parameter int WORD_W     = 32,
   parameter int N_WORDS    = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start,
   input  logic [3:0]                  cmd,
   input  logic [ADDR_W-1:0]           addr,
   input  logic [$clog2(N_WORDS*WORD_W/8):0] nbytes,
   input  logic [N_WORDS*WORD_W-1:0]   wdata,
   output logic                        busy,
   output logic                        done,
   output logic [2:0]                  status,
   output logic [N_WORDS*WORD_W-1:0]   rdata,
   input  logic                        ch_active,
   output logic                        ch_req,
   input  logic                        ch_grant,
   input  logic                        ch_sink,
   output logic                        ch_load,
   output logic [N_WORDS*WORD_W-1:0]   ch_wdata,
   output logic [15:0]                 ch_ctrl,
   output logic [ADDR_W-1:0]           ch_addr,
   output logic                        ch_reset,
   output logic                        ch_go,
   input  logic                        ch_done,
   input  logic [7:0]                  ch_err,
   input  logic [N_WORDS*WORD_W-1:0]   ch_rdata
);
   localparam int DATA_W  = N_WORDS * WORD_W;
   localparam int MAX_B   = DATA_W / 8;
   localparam int LEN_W   = $clog2(MAX_B) + 1;
   localparam int CMD_W   = 4;
   localparam int CNT_FW  = 8;
   localparam int CTRL_W  = 16;
   localparam int MAX_US  = (IDLE_US > GRANT_US ? IDLE_US : GRANT_US) > (GO_US > BACKOFF_US ? GO_US : BACKOFF_US)
                            ? (IDLE_US > GRANT_US ? IDLE_US : GRANT_US)
                            : (GO_US > BACKOFF_US ? GO_US : BACKOFF_US);
   localparam int TMR_W   = $clog2(MAX_US + 1) + 1;

   if (MAX_B > (1 << CNT_FW)) begin : g_bad_len
      $error("aux_xact_seq: byte count does not fit the control field");
   end
   if (WORD_W % 8 != 0) begin : g_bad_word
      $error("aux_xact_seq: WORD_W must be a whole number of bytes");
   end

   logic [CMD_W-1:0]  cmd_q;
   logic [ADDR_W-1:0] addr_q;
   logic [LEN_W-1:0]  len_q;
   logic              err_q;
   logic              tick, tmr_clr, tmr_exp;
   logic [TMR_W-1:0]  tmr_limit;
   logic              accept, sample_resp, commit_rd;

   aux_us_tick #(.CYC_PER_US(CYC_PER_US)) tick_i (
      .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .tick(tick)
   );

   aux_us_timer #(.CNT_W(TMR_W)) timer_i (
      .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .tick(tick),
      .limit(tmr_limit), .expired(tmr_exp)
   );

   aux_xact_fsm #(
      .MAX_TRIES(MAX_TRIES), .TMR_W(TMR_W), .IDLE_US(IDLE_US),
      .GRANT_US(GRANT_US), .GO_US(GO_US), .BACKOFF_US(BACKOFF_US)
   ) fsm_i (
      .clk(clk), .rst_n(rst_n), .start(start), .is_read(cmd_q[0]),
      .ch_active(ch_active), .ch_grant(ch_grant), .ch_sink(ch_sink),
      .ch_done(ch_done), .err_any(err_q), .tmr_exp(tmr_exp),
      .tmr_clr(tmr_clr), .tmr_limit(tmr_limit), .accept(accept),
      .sample_resp(sample_resp), .commit_rd(commit_rd), .busy(busy),
      .done(done), .status(status), .ch_req(ch_req), .ch_load(ch_load),
      .ch_reset(ch_reset), .ch_go(ch_go)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q  <= '0;
         addr_q <= '0;
         len_q  <= LEN_W'(1);
         err_q  <= 1'b0;
      end else begin
         if (accept) begin
            cmd_q  <= cmd;
            addr_q <= addr;
            len_q  <= nbytes;
         end
         if (sample_resp) err_q <= |ch_err;
      end
   end

   for (genvar w = 0; w < N_WORDS; w++) begin : g_word
      logic [WORD_W-1:0] wr_q, stage_q, rd_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wr_q    <= '0;
            stage_q <= '0;
            rd_q    <= '0;
         end else begin
            if (accept)      wr_q    <= wdata[w*WORD_W +: WORD_W];
            if (sample_resp) stage_q <= ch_rdata[w*WORD_W +: WORD_W];
            if (commit_rd)   rd_q    <= stage_q;
         end
      end
      assign ch_wdata[w*WORD_W +: WORD_W] = wr_q;
      assign rdata[w*WORD_W +: WORD_W]    = rd_q;
   end

   assign ch_ctrl = {cmd_q, {(CTRL_W-CMD_W-CNT_FW){1'b0}}, CNT_FW'(len_q - LEN_W'(1))};
   assign ch_addr = addr_q;

   // R11
   req_low_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !ch_req);
   // R6
   ctrl_stable_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_go && $past(ch_go)) |-> ($stable(ch_ctrl) && $stable(ch_addr)));
   // R7
   reset_go_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ch_reset && ch_go));
endmodule

// File: tb/aux_xact_seq_tb.sv
module aux_xact_seq_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int CYC = 2;
   localparam int IDLE_US = 10, GRANT_US = 10, GO_US = 12, BACKOFF_US = 5, MAX_TRIES = 5;
   localparam int GO_WIN = GO_US * CYC + 1;
   localparam int RETRY_GAP = BACKOFF_US * CYC + 2;

   logic clk = 0, rst_n = 0;
   logic start = 0;
   logic [3:0] cmd = 0;
   logic [19:0] addr = 0;
   logic [4:0] nbytes = 1;
   logic [127:0] wdata = 0;
   logic busy, done;
   logic [2:0] status;
   logic [127:0] rdata;
   logic ch_active = 0, ch_grant = 0, ch_sink = 1, ch_done = 0;
   logic ch_req, ch_load, ch_reset, ch_go;
   logic [127:0] ch_wdata, ch_rdata = 0;
   logic [15:0] ch_ctrl;
   logic [19:0] ch_addr;
   logic [7:0] ch_err = 0;

   int errors = 0, checks = 0, cyc = 0;

   // channel model knobs
   int grant_lat = 0, go_lat = 3, fail_n = 0;
   logic [7:0] err_pat = 8'h10;
   logic [127:0] rd_pat = 0;
   // observations
   int n_load, n_reset, n_go, att, g_cnt, go_cnt, gap_cnt, go_hi;
   int first_gap, min_rgap, max_rgap, n_req;
   logic [127:0] seen_wdata;
   logic [15:0] seen_ctrl;
   logic [19:0] seen_addr;
   logic load_before_reset;
   logic p_reset = 0, p_go = 0, p_load = 0;
   logic [127:0] exp_rdata = 0;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc++;

   aux_xact_seq #(.CYC_PER_US(CYC), .IDLE_US(IDLE_US), .GRANT_US(GRANT_US),
                  .GO_US(GO_US), .BACKOFF_US(BACKOFF_US), .MAX_TRIES(MAX_TRIES)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .addr(addr), .nbytes(nbytes),
      .wdata(wdata), .busy(busy), .done(done), .status(status), .rdata(rdata),
      .ch_active(ch_active), .ch_req(ch_req), .ch_grant(ch_grant), .ch_sink(ch_sink),
      .ch_load(ch_load), .ch_wdata(ch_wdata), .ch_ctrl(ch_ctrl), .ch_addr(ch_addr),
      .ch_reset(ch_reset), .ch_go(ch_go), .ch_done(ch_done), .ch_err(ch_err),
      .ch_rdata(ch_rdata));

   // channel model: samples and drives at the falling edge
   always @(negedge clk) begin
      ch_done = 0;
      if (ch_req) begin
         n_req++;
         g_cnt++;
         ch_grant = (grant_lat >= 0) && (g_cnt > grant_lat);
      end else begin
         g_cnt = 0;
         ch_grant = 0;
      end
      if (ch_load && !p_load) begin
         n_load++;
         seen_wdata = ch_wdata;
         load_before_reset = (n_reset == 0);
      end
      if (ch_reset && !p_reset) n_reset++;
      if (ch_reset) gap_cnt = 0;
      else if (!ch_go) gap_cnt++;
      if (ch_go && !p_go) begin
         n_go++;
         seen_ctrl = ch_ctrl;
         seen_addr = ch_addr;
         if (n_go == 1) first_gap = gap_cnt;
         else begin
            if (gap_cnt < min_rgap) min_rgap = gap_cnt;
            if (gap_cnt > max_rgap) max_rgap = gap_cnt;
         end
      end
      if (ch_go) begin
         go_cnt++;
         go_hi++;
         if (go_lat > 0 && go_cnt == go_lat) begin
            att++;
            ch_done = 1;
            ch_err = (att <= fail_n) ? err_pat : 8'h00;
            ch_rdata = rd_pat;
         end
      end else go_cnt = 0;
      p_reset = ch_reset; p_go = ch_go; p_load = ch_load;
   end

   task automatic chk(input logic ok, input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_ctrl(input logic [3:0] c, input logic [4:0] n);
      return {c, 4'h0, 8'(n - 5'd1)};
   endfunction

   logic [2:0] got_status;
   logic got_req;
   int got_done_len;

   task automatic run_xact(input logic [3:0] c, input logic [19:0] a, input logic [4:0] n,
                           input logic [127:0] wd);
      n_load = 0; n_reset = 0; n_go = 0; att = 0; g_cnt = 0; go_cnt = 0; gap_cnt = 0;
      go_hi = 0; first_gap = -1; min_rgap = 1 << 20; max_rgap = -1; n_req = 0;
      load_before_reset = 0;
      @(negedge clk);
      cmd = c; addr = a; nbytes = n; wdata = wd; start = 1;
      @(negedge clk);
      start = 0;
      while (!done) @(negedge clk);
      got_status = status;
      got_req = ch_req;
      @(negedge clk);
      got_done_len = done ? 2 : 1;
   endtask

   // write/read expectations common to successful transactions
   task automatic chk_ok_xact(input logic [3:0] c, input logic [19:0] a, input logic [4:0] n,
                              input logic [127:0] wd, input int fails);
      chk(got_status == 3'd0, "R9 status ok", got_status, 0);
      chk(n_go == fails + 1, "R9 attempts", n_go, fails + 1);
      chk(n_reset == fails + 1, "R7 reset pulses", n_reset, fails + 1);
      chk(seen_ctrl == exp_ctrl(c, n), "R6 ctrl word", seen_ctrl, exp_ctrl(c, n));
      chk(seen_addr == a, "R6 address", seen_addr, a);
      if (!c[0]) begin
         chk(n_load == 1 && seen_wdata == wd && load_before_reset, "R5 write load", seen_wdata, wd);
      end else begin
         chk(n_load == 0, "R5 no load on read", n_load, 0);
         exp_rdata = rd_pat;
      end
      chk(rdata == exp_rdata, "R10 read data", rdata, exp_rdata);
      chk(first_gap == 1, "R7 first gap", first_gap, 1);
      if (fails > 0)
         chk(min_rgap == RETRY_GAP && max_rgap == RETRY_GAP, "R7 backoff gap", min_rgap, RETRY_GAP);
      chk(!got_req && got_done_len == 1, "R11 done strobe", got_req, 0);
   endtask

   initial begin
      int seed_dummy;
      seed_dummy = $urandom(32'd4242);
      repeat (3) @(negedge clk);
      chk(!busy && !done && !ch_req && !ch_reset && !ch_go && !ch_load, "R1 reset state",
          {busy, done, ch_req, ch_reset, ch_go, ch_load}, 0);
      rst_n = 1;
      @(negedge clk);
      chk(!busy && !done && !ch_req && !ch_go, "R1 after release", {busy, done, ch_req, ch_go}, 0);

      // R2: channel never goes idle
      ch_active = 1;
      run_xact(4'h9, 20'h00100, 5'd4, 0);
      chk(got_status == 3'd1, "R2 idle timeout busy", got_status, 1);
      chk(n_req == 0 && n_go == 0, "R2 no request or go", n_req, 0);
      ch_active = 0;

      // R3: grant never arrives
      grant_lat = -1;
      run_xact(4'h8, 20'h00200, 5'd2, 128'h55);
      chk(got_status == 3'd1, "R3 grant timeout busy", got_status, 1);
      chk(!got_req && n_go == 0 && n_load == 0, "R3 request dropped", got_req, 0);
      grant_lat = 2;

      // R4: no sink
      ch_sink = 0;
      run_xact(4'h8, 20'h00300, 5'd1, 128'h77);
      chk(got_status == 3'd2, "R4 nodev", got_status, 2);
      chk(n_load == 0 && n_reset == 0 && n_go == 0, "R4 nothing issued", n_load + n_reset + n_go, 0);
      chk(!got_req, "R11 req low nodev", got_req, 0);
      ch_sink = 1;

      // R9: retries exhausted
      fail_n = MAX_TRIES; err_pat = 8'h01; go_lat = 2;
      rd_pat = 128'hdead;
      run_xact(4'h9, 20'h00400, 5'd16, 0);
      chk(got_status == 3'd4, "R9 remote io", got_status, 4);
      chk(n_go == MAX_TRIES, "R9 attempt cap", n_go, MAX_TRIES);
      chk(rdata == exp_rdata, "R10 rdata kept on failure", rdata, exp_rdata);
      chk(min_rgap == RETRY_GAP, "R7 backoff on retries", min_rgap, RETRY_GAP);

      // R9: last allowed attempt succeeds (error in upper field)
      fail_n = MAX_TRIES - 1; err_pat = 8'h20; rd_pat = 128'h0123_4567_89ab_cdef;
      run_xact(4'h9, 20'hfffff, 5'd16, 0);
      chk_ok_xact(4'h9, 20'hfffff, 5'd16, 0, MAX_TRIES - 1);

      // R8: no completion -> timeout, single attempt
      fail_n = 0; go_lat = 0;
      run_xact(4'h8, 20'h00500, 5'd3, 128'h1);
      chk(got_status == 3'd3, "R8 go timeout", got_status, 3);
      chk(go_hi == GO_WIN && n_go == 1, "R8 go window length", go_hi, GO_WIN);

      // R12: completion on the last cycle of the window wins
      go_lat = GO_WIN; rd_pat = 128'hbeef;
      run_xact(4'h1, 20'h00600, 5'd5, 0);
      chk(got_status == 3'd0, "R12 completion wins at expiry", got_status, 0);
      exp_rdata = rd_pat;
      chk(rdata == exp_rdata, "R12 reply kept", rdata, exp_rdata);
      go_lat = GO_WIN + 1;
      run_xact(4'h1, 20'h00601, 5'd5, 0);
      chk(got_status == 3'd3, "R12 one cycle late times out", got_status, 3);
      chk(go_hi == GO_WIN, "R8 late go window", go_hi, GO_WIN);

      // random transactions
      for (int i = 0; i < 40; i++) begin
         logic [3:0] c; logic [19:0] a; logic [4:0] n; logic [127:0] wd; int f;
         c = 4'($urandom);
         a = 20'($urandom);
         n = 5'($urandom_range(1, 16));
         wd = {$urandom, $urandom, $urandom, $urandom};
         f = $urandom_range(0, 2);
         fail_n = f;
         err_pat = ($urandom_range(0, 1) == 0) ? 8'h40 : 8'h02;
         go_lat = $urandom_range(1, 6);
         grant_lat = $urandom_range(0, 5);
         rd_pat = {$urandom, $urandom, $urandom, $urandom};
         run_xact(c, a, n, wd);
         chk_ok_xact(c, a, n, wd, f);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule